// File: doc/BRIEF.md
# JTAG In-System-Programming Mode Controller

This block sits behind a JTAG instruction register. Each time the TAP controller finishes Update-IR, the block decodes the 10-bit instruction word. It also keeps the in-system-programming (ISP) mode of the device. The mode is sticky. Only one of the two enabling instructions can enter it, and it is left only through a disabling instruction followed by a timed dwell in Run-Test/Idle. While the mode is active, the block drives the I/O pin controls. In the high-impedance variant every I/O pin is tri-stated. In the clamped variant every I/O pin follows the boundary-scan register, and the core logic is frozen.

The block also picks which data register sits between TDI and TDO, and it raises one-cycle strobes for the flash program, erase and read operations. These strobes fire when the TAP moves into Run-Test/Idle. The read path supports burst access by flagging an address auto-increment on each read after the first one. Outside ISP mode, every programming-class instruction is gated off and falls back to the bypass register.

All inputs are synchronous to `clk`. The exit dwell is counted in `clk` cycles and is derived from the parameters `CLK_KHZ` and `DWELL_US`. The default dwell is 200 µs.

Top module: `isp_mode_ctrl`

## Requirements
- R1: After reset, `isp_active`, `io_tristate`, `io_clamp`, `core_freeze`, all strobes and `addr_inc` are low, and `dr_sel` is 0 (bypass).
- R2: An update of 10'b10_1100_1100 enters ISP mode in high-impedance form. One clock later, `isp_active` and `io_tristate` are high, and `io_clamp` and `core_freeze` are low.
- R3: An update of 10'b10_0011_0011 enters ISP mode in clamped form. One clock later, `isp_active`, `io_clamp` and `core_freeze` are high, and `io_tristate` is low.
- R4: While in ISP mode, updating any instruction other than the two enables leaves `isp_active`, `io_tristate`, `io_clamp` and `core_freeze` unchanged. Mode can only end through R5.
- R5: After an update of 10'b10_0000_0001 (exit) while in ISP mode, the mode clears at the clock edge that completes `DWELL_CYCLES = CLK_KHZ*DWELL_US/1000` consecutive cycles with `tap_idle` high. Before that edge, the mode stays unchanged.
- R6: If `tap_idle` drops before the dwell completes, the dwell count restarts from zero.
- R7: Outside ISP mode, the codes for program (10'b10_1111_0100), no-op (10'b10_0001_0000), address shift (10'b10_0000_0011), erase (10'b10_1111_0010) and read (10'b10_0000_0101) are ignored. They select bypass (`dr_sel`=0) and raise no strobe.
- R8: `dr_sel` encodes the selected data register as 0 bypass, 1 one-bit default register, 2 flash address register, 3 flash data register. In ISP mode, no-op, erase, enable and exit select 1, address shift selects 2, and program and read select 3. Exit outside ISP mode selects 1.
- R9: While in ISP mode with program, erase or read as the current instruction, the first cycle of `tap_idle` high after it was low yields a one-cycle pulse on `prog_strobe`, `erase_strobe` or `read_strobe` respectively, on the next clock.
- R10: `addr_inc` pulses together with `read_strobe` on every read strobe except the first one after the read instruction was updated.
- R11: An unrecognised opcode selects bypass (`dr_sel`=0) and raises no strobe, in or out of ISP mode.
- R12: Any instruction update while an exit is pending cancels that exit. Re-issuing an enable while in ISP mode switches to that enable's form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; also times the exit dwell |
| rst_n | input | 1 | Active-low synchronous reset |
| tap_idle | input | 1 | TAP controller is in Run-Test/Idle |
| upd_ir | input | 1 | One-cycle pulse at Update-IR |
| ir_word | input | 10 | Instruction register contents, valid with `upd_ir` |
| isp_active | output | 1 | ISP mode is active |
| io_tristate | output | 1 | Tri-state all I/O pins |
| io_clamp | output | 1 | Drive I/O pins from the boundary-scan register |
| core_freeze | output | 1 | Freeze core logic and registers |
| dr_sel | output | 2 | Data register select (0 bypass, 1 default, 2 address, 3 data) |
| prog_strobe | output | 1 | Flash program pulse |
| erase_strobe | output | 1 | Flash erase pulse |
| read_strobe | output | 1 | Flash read pulse |
| addr_inc | output | 1 | Burst read address increment, with `read_strobe` |

## Verification
A corrupted mode register shows up one clock after the offending update. It appears as a wrong combination on `isp_active`, `io_tristate`, `io_clamp` and `core_freeze`, or as a programming opcode that still selects bypass. A dwell counter that runs short, long or without restarting shows up only at the end of the dwell, as `isp_active` falling one edge early or late. The bench therefore samples the edges either side of that point. A bad burst flag or gate stays hidden until the next entry into Run-Test/Idle, when a strobe or `addr_inc` appears on the wrong cycle or not at all.

// File: rtl/isp_pkg.sv
package isp_pkg;

  localparam int IR_W = 10;
  localparam int SEL_W = 2;

  localparam logic [IR_W-1:0] OPC_HIZ     = 10'b10_1100_1100;
  localparam logic [IR_W-1:0] OPC_CLAMP   = 10'b10_0011_0011;
  localparam logic [IR_W-1:0] OPC_EXIT    = 10'b10_0000_0001;
  localparam logic [IR_W-1:0] OPC_PROGRAM = 10'b10_1111_0100;
  localparam logic [IR_W-1:0] OPC_NOOP    = 10'b10_0001_0000;
  localparam logic [IR_W-1:0] OPC_ADDR    = 10'b10_0000_0011;
  localparam logic [IR_W-1:0] OPC_ERASE   = 10'b10_1111_0010;
  localparam logic [IR_W-1:0] OPC_READ    = 10'b10_0000_0101;

  typedef enum logic [3:0] {
    INS_BYPASS,
    INS_HIZ,
    INS_CLAMP,
    INS_EXIT,
    INS_PROGRAM,
    INS_NOOP,
    INS_ADDR,
    INS_ERASE,
    INS_READ
  } ins_e;

  typedef enum logic [1:0] {
    MODE_OFF,
    MODE_HIZ,
    MODE_CLAMP
  } mode_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_BYPASS  = 2'd0,
    SEL_DEFAULT = 2'd1,
    SEL_ADDR    = 2'd2,
    SEL_DATA    = 2'd3
  } sel_e;

  function automatic sel_e route_of(ins_e ins);
    case (ins)
      INS_HIZ, INS_CLAMP, INS_EXIT, INS_NOOP, INS_ERASE: route_of = SEL_DEFAULT;
      INS_ADDR:                                          route_of = SEL_ADDR;
      INS_PROGRAM, INS_READ:                             route_of = SEL_DATA;
      default:                                           route_of = SEL_BYPASS;
    endcase
  endfunction

endpackage

// File: rtl/isp_decode.sv
module isp_decode
  import isp_pkg::*;
(
  input  logic [IR_W-1:0] opcode,
  input  logic            in_isp,
  output ins_e            ins
);

  ins_e raw;

  always_comb begin
    case (opcode)
      OPC_HIZ:     raw = INS_HIZ;
      OPC_CLAMP:   raw = INS_CLAMP;
      OPC_EXIT:    raw = INS_EXIT;
      OPC_PROGRAM: raw = INS_PROGRAM;
      OPC_NOOP:    raw = INS_NOOP;
      OPC_ADDR:    raw = INS_ADDR;
      OPC_ERASE:   raw = INS_ERASE;
      OPC_READ:    raw = INS_READ;
      default:     raw = INS_BYPASS;
    endcase
  end

  // enable and exit pass in any mode; programming class needs ISP mode
  always_comb begin
    case (raw)
      INS_HIZ, INS_CLAMP, INS_EXIT, INS_BYPASS: ins = raw;
      default: ins = in_isp ? raw : INS_BYPASS;
    endcase
  end

endmodule

// File: rtl/isp_mode_fsm.sv
module isp_mode_fsm
  import isp_pkg::*;
#(
  parameter int DWELL_CYCLES = 2000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  upd_ir,
  input  ins_e  new_ins,
  input  logic  tap_idle,
  output mode_e mode
);

  localparam int CNT_W = $clog2(DWELL_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYCLES - 1);

  logic             pending;
  logic [CNT_W-1:0] dwell;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= MODE_OFF;
      pending <= 1'b0;
      dwell   <= '0;
    end else if (upd_ir) begin
      dwell <= '0;
      case (new_ins)
        INS_HIZ: begin
          mode    <= MODE_HIZ;
          pending <= 1'b0;
        end
        INS_CLAMP: begin
          mode    <= MODE_CLAMP;
          pending <= 1'b0;
        end
        INS_EXIT: pending <= (mode != MODE_OFF);
        default:  pending <= 1'b0;
      endcase
    end else if (pending) begin
      if (!tap_idle) begin
        dwell <= '0;
      end else if (dwell == LAST) begin
        mode    <= MODE_OFF;
        pending <= 1'b0;
        dwell   <= '0;
      end else begin
        dwell <= dwell + 1'b1;
      end
    end
  end

endmodule

// File: rtl/isp_strobe_gen.sv
module isp_strobe_gen
  import isp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic upd_ir,
  input  logic tap_idle,
  input  logic in_isp,
  input  ins_e cur_ins,
  output logic prog_strobe,
  output logic erase_strobe,
  output logic read_strobe,
  output logic addr_inc
);

  logic idle_q;
  logic read_seen;
  logic fire;

  assign fire = tap_idle && !idle_q && in_isp && !upd_ir;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q       <= 1'b0;
      read_seen    <= 1'b0;
      prog_strobe  <= 1'b0;
      erase_strobe <= 1'b0;
      read_strobe  <= 1'b0;
      addr_inc     <= 1'b0;
    end else begin
      idle_q       <= tap_idle;
      prog_strobe  <= fire && (cur_ins == INS_PROGRAM);
      erase_strobe <= fire && (cur_ins == INS_ERASE);
      read_strobe  <= fire && (cur_ins == INS_READ);
      addr_inc     <= fire && (cur_ins == INS_READ) && read_seen;
      if (upd_ir)
        read_seen <= 1'b0;
      else if (fire && cur_ins == INS_READ)
        read_seen <= 1'b1;
    end
  end

endmodule

// File: rtl/isp_mode_ctrl.sv
module isp_mode_ctrl
  import isp_pkg::*;
#(
  parameter int CLK_KHZ  = 10000,
  parameter int DWELL_US = 200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tap_idle,
  input  logic            upd_ir,
  input  logic [IR_W-1:0] ir_word,
  output logic            isp_active,
  output logic            io_tristate,
  output logic            io_clamp,
  output logic            core_freeze,
  output logic [SEL_W-1:0] dr_sel,
  output logic            prog_strobe,
  output logic            erase_strobe,
  output logic            read_strobe,
  output logic            addr_inc
);

  localparam int DWELL_CYCLES = (CLK_KHZ * DWELL_US) / 1000;

  ins_e  dec_ins;
  ins_e  cur_ins;
  mode_e mode;

  isp_decode u_decode (
    .opcode (ir_word),
    .in_isp (isp_active),
    .ins    (dec_ins)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      cur_ins <= INS_BYPASS;
    else if (upd_ir)
      cur_ins <= dec_ins;
  end

  isp_mode_fsm #(
    .DWELL_CYCLES (DWELL_CYCLES)
  ) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_ir   (upd_ir),
    .new_ins  (dec_ins),
    .tap_idle (tap_idle),
    .mode     (mode)
  );

  isp_strobe_gen u_strobe (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_ir       (upd_ir),
    .tap_idle     (tap_idle),
    .in_isp       (isp_active),
    .cur_ins      (cur_ins),
    .prog_strobe  (prog_strobe),
    .erase_strobe (erase_strobe),
    .read_strobe  (read_strobe),
    .addr_inc     (addr_inc)
  );

  assign isp_active  = (mode != MODE_OFF);
  assign io_tristate = (mode == MODE_HIZ);
  assign io_clamp    = (mode == MODE_CLAMP);
  assign core_freeze = (mode == MODE_CLAMP);
  assign dr_sel      = route_of(cur_ins);

endmodule

// File: rtl/isp_mode_ctrl_chk.sv
module isp_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tap_idle,
  input logic       upd_ir,
  input logic [9:0] ir_word,
  input logic       isp_active,
  input logic       io_tristate,
  input logic       io_clamp,
  input logic       core_freeze,
  input logic [1:0] dr_sel,
  input logic       prog_strobe,
  input logic       erase_strobe,
  input logic       read_strobe,
  input logic       addr_inc
);

  assert_hiz_form_R2: assert property (@(posedge clk) disable iff (!rst_n)
    io_tristate |-> (isp_active && !io_clamp && !core_freeze));

  assert_clamp_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
    io_clamp |-> (isp_active && core_freeze && !io_tristate));

  // exit needs a dwell cycle in Run-Test/Idle with no update
  assert_mode_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (isp_active && !upd_ir && !tap_idle) |=> isp_active);

  assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_strobe, erase_strobe, read_strobe}));

  assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_strobe || erase_strobe || read_strobe) |=> !(prog_strobe || erase_strobe || read_strobe));

  assert_strobe_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_strobe || erase_strobe || read_strobe) |-> isp_active);

  assert_burst_with_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_inc |-> read_strobe);

  assert_route_outside_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !isp_active |-> (dr_sel <= 2'd1));

endmodule

bind isp_mode_ctrl isp_mode_ctrl_chk u_chk (.*);

// File: tb/test_isp_mode_ctrl.sv
module test_isp_mode_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DWELL = 20;  // CLK_KHZ=100, DWELL_US=200

  localparam logic [9:0] HIZ = 10'h2CC, CLAMP = 10'h233, EXIT = 10'h201,
    PROG = 10'h2F4, NOOP = 10'h210, ADDR = 10'h203, ERASE = 10'h2F2, READ = 10'h205;

  // {opcode, active, tristate, clamp, dr_sel}
  localparam int NV = 11;
  localparam logic [14:0] VEC [NV] = '{
    {READ,   1'b0, 1'b0, 1'b0, 2'd0},   // R7 gated
    {10'h3FF,1'b0, 1'b0, 1'b0, 2'd0},   // R11
    {EXIT,   1'b0, 1'b0, 1'b0, 2'd1},   // R8 exit outside
    {HIZ,    1'b1, 1'b1, 1'b0, 2'd1},   // R2
    {NOOP,   1'b1, 1'b1, 1'b0, 2'd1},   // R4 R8
    {ADDR,   1'b1, 1'b1, 1'b0, 2'd2},   // R8
    {PROG,   1'b1, 1'b1, 1'b0, 2'd3},   // R8
    {CLAMP,  1'b1, 1'b0, 1'b1, 2'd1},   // R3 R12
    {ERASE,  1'b1, 1'b0, 1'b1, 2'd1},   // R4
    {READ,   1'b1, 1'b0, 1'b1, 2'd3},   // R8
    {10'h155,1'b1, 1'b0, 1'b1, 2'd0}    // R11
  };

  logic clk = 0, rst_n = 0, tap_idle = 0, upd_ir = 0;
  logic [9:0] ir_word = '0;
  logic isp_active, io_tristate, io_clamp, core_freeze;
  logic [1:0] dr_sel;
  logic prog_strobe, erase_strobe, read_strobe, addr_inc;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isp_mode_ctrl #(.CLK_KHZ(100), .DWELL_US(200)) i_isp_mode_ctrl (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [9:0] op);
    @(negedge clk); ir_word = op; upd_ir = 1;
    @(negedge clk); upd_ir = 0;
  endtask

  task automatic mode_is(input string req, input int a, input int t, input int c);
    chk({req, " active"}, isp_active, a);
    chk({req, " tristate"}, io_tristate, t);
    chk({req, " clamp"}, io_clamp, c);
    chk({req, " freeze"}, core_freeze, c);
  endtask

  // raise idle, check strobes the cycle after, then drop idle
  task automatic idle_pulse(input string req, input int p, input int e, input int r, input int inc);
    @(negedge clk); tap_idle = 1;
    @(negedge clk);
    chk({req, " prog"}, prog_strobe, p);
    chk({req, " erase"}, erase_strobe, e);
    chk({req, " read"}, read_strobe, r);
    chk({req, " inc"}, addr_inc, inc);
    tap_idle = 0;
    @(negedge clk);
    chk({req, " pulse width"}, prog_strobe | erase_strobe | read_strobe, 0);
  endtask

  task automatic do_reset();
    rst_n = 0; tap_idle = 0; upd_ir = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    // R1
    mode_is("R1", 0, 0, 0);
    chk("R1 dr_sel", dr_sel, 0);
    chk("R1 strobes", {prog_strobe, erase_strobe, read_strobe, addr_inc}, 0);

    for (int i = 0; i < NV; i++) begin
      load(VEC[i][14:5]);
      mode_is($sformatf("R4 vec%0d", i), VEC[i][4], VEC[i][3], VEC[i][2]);
      chk($sformatf("R8 vec%0d dr_sel", i), dr_sel, VEC[i][1:0]);
    end

    // R9 R10 strobes in clamp mode
    load(PROG);  idle_pulse("R9 program", 1, 0, 0, 0);
    load(ERASE); idle_pulse("R9 erase", 0, 1, 0, 0);
    load(READ);  idle_pulse("R10 first read", 0, 0, 1, 0);
    idle_pulse("R10 burst read", 0, 0, 1, 1);
    idle_pulse("R10 burst read2", 0, 0, 1, 1);
    load(READ);  idle_pulse("R10 reload read", 0, 0, 1, 0);
    load(10'h155); idle_pulse("R11 unknown", 0, 0, 0, 0);

    // R5 R6 exit dwell with restart
    load(EXIT);
    chk("R8 exit dr_sel", dr_sel, 1);
    @(negedge clk); tap_idle = 1;
    repeat (DWELL-1) @(negedge clk);
    chk("R6 before drop", isp_active, 1);
    tap_idle = 0;
    @(negedge clk); tap_idle = 1;
    repeat (DWELL-1) @(negedge clk);
    chk("R6 restarted dwell", isp_active, 1);
    mode_is("R5 clamp held", 1, 0, 1);
    @(negedge clk);
    mode_is("R5 exit done", 0, 0, 0);
    tap_idle = 0;

    // R7 gated after exit
    load(PROG);
    chk("R7 dr_sel", dr_sel, 0);
    idle_pulse("R7 gated program", 0, 0, 0, 0);
    load(ERASE); idle_pulse("R7 gated erase", 0, 0, 0, 0);

    // R12 cancel pending exit, re-enable switches form
    load(HIZ);
    load(EXIT);
    @(negedge clk); tap_idle = 1;
    repeat (5) @(negedge clk);
    tap_idle = 0;
    load(NOOP);
    @(negedge clk); tap_idle = 1;
    repeat (DWELL+5) @(negedge clk);
    tap_idle = 0;
    mode_is("R12 exit cancelled", 1, 1, 0);
    load(CLAMP);
    mode_is("R12 switch form", 1, 0, 1);

    // R5 plain exit, exact edge
    load(EXIT);
    @(negedge clk); tap_idle = 1;
    repeat (DWELL-1) @(negedge clk);
    chk("R5 one edge early", isp_active, 1);
    @(negedge clk);
    chk("R5 on time", isp_active, 0);
    tap_idle = 0;

    // R1 mid-run reset
    load(HIZ);
    do_reset();
    mode_is("R1 re-reset", 0, 0, 0);
    chk("R1 re-reset dr_sel", dr_sel, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule